// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Address Translation Buffer

This block is a small, fully associative translation cache. It turns a 64-bit effective address into a 42-bit real address. Each of its entries describes one page and carries the following:

- an effective page number
- a page-size code
- a guest-space bit, a partition tag, an address-space bit and a translation ID
- an indirect flag
- a real page number
- a stored parity bit

On a lookup, every entry is compared against the request at the same time. Each compare ignores the address bits that lie inside that entry's page. The result is registered and appears one clock later. It gives either a hit, or a miss classified by the kind of access.

A hit reports the entry index and whether the entry is a direct translation or a pointer into a page table. For a direct translation it also reports the real address. A page-table pointer needs further handling elsewhere, so no address is reported for it. A single write port loads or invalidates one entry per cycle. The parity bit is computed at write time, and the port can deliberately store a wrong parity bit for error injection.

Five page sizes are supported, from 4 KB to 1 GB. Every one is a power of four times 1 KB. The architectural 5-bit size code therefore always has a zero low bit, so entries store only the upper four bits.

Top module: `tlb_xlate`

## Requirements
- R1: Synchronous reset clears all entry valid bits and drives every result output to zero.
- R2: Stored size codes 1, 3, 5, 7 and 10 select page offsets of 12, 16, 20, 24 and 30 bits (4 KB, 64 KB, 1 MB, 16 MB and 1 GB). An entry holding any other code never matches.
- R3: An entry matches only if all of the following hold: it is valid; its page number equals effective address bits [63:offset]; and its guest-space bit, partition tag, address-space bit and translation ID all equal the lookup's.
- R4: On a direct hit, `rs_ra` equals the entry's real page number above the page offset, concatenated with effective address bits [offset-1:0]. The result is 42 bits wide.
- R5: A hit on an entry whose indirect flag is 1 sets `rs_ind` and reports `rs_ra` as zero. On a miss, `rs_ind` is 0 and `rs_ra` is 0.
- R6: A miss with `lk_is_ifetch` = 1 sets `rs_imiss`, whatever the value of `lk_is_cmo`.
- R7: A data miss (`lk_is_ifetch` = 0) sets `rs_dmiss` unless `lk_is_cmo` = 1. In that case neither miss flag is set.
- R8: When several entries match, `rs_multi` is set and `rs_idx` and the translation come from the lowest matching index. `rs_idx` is defined only when `rs_hit` is 1.
- R9: The stored parity bit makes the entry fields plus parity even. `wr_perr_inject` = 1 stores the inverted bit. `rs_perr` is set when any matching entry fails its parity check.
- R10: Results appear in the cycle after `lk_valid`. A write becomes visible to lookups from the next cycle, so a lookup at the same edge as the write sees the old contents.
- R11: With `lk_valid` = 0, all of the following are 0 in the next cycle: `rs_valid`, `rs_hit`, `rs_ind`, `rs_multi`, `rs_perr`, both miss flags and `rs_ra`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 4 | Entry index to write |
| wr_valid | input | 1 | Valid bit to store (0 invalidates the entry) |
| wr_epn | input | 52 | Effective page number, effective address bits [63:12] |
| wr_gs | input | 1 | Guest-space tag |
| wr_lpid | input | 8 | Partition tag |
| wr_ts | input | 1 | Address-space bit |
| wr_tid | input | 14 | Translation ID |
| wr_size | input | 4 | Reduced page-size code |
| wr_ind | input | 1 | Indirect (page-table pointer) flag |
| wr_rpn | input | 30 | Real page number, real address bits [41:12] |
| wr_perr_inject | input | 1 | Store inverted parity |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 64 | Effective address |
| lk_gs | input | 1 | Lookup guest-space tag |
| lk_lpid | input | 8 | Lookup partition tag |
| lk_ts | input | 1 | Lookup address-space bit |
| lk_tid | input | 14 | Lookup translation ID |
| lk_is_ifetch | input | 1 | Access is an instruction fetch |
| lk_is_cmo | input | 1 | Data access is a cache-management operation |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | A matching entry was found |
| rs_idx | output | 4 | Index of the selected entry |
| rs_ind | output | 1 | Hit is a page-table pointer |
| rs_ra | output | 42 | Real address of a direct hit |
| rs_imiss | output | 1 | Instruction-fetch miss |
| rs_dmiss | output | 1 | Data-access miss |
| rs_multi | output | 1 | More than one entry matched |
| rs_perr | output | 1 | Parity failure on a matching entry |

## Verification
The bench fills the buffer with every legal size code and two illegal ones, then probes each entry in several ways:

- **Page-number bits.** It flips the lowest page-number bit just above the offset; a wrong mask would still hit. It flips an offset bit; a wrong mask would miss. It checks the real address; an off-by-one boundary between the page number and the offset would corrupt it.
- **Tags.** It flips each context tag in turn. A design that left a tag out of the compare would still hit.
- **Duplicates.** Matching entries are loaded at two indices. A wrong priority would report the higher index or that entry's translation.
- **Parity.** A corrupted parity bit is injected. A design that skipped the check, or computed it over the wrong fields, would stay silent.
- **Access kinds.** All four access-kind combinations are swept on misses. A design with a wrong rule would flag a cache-management miss or drop a fetch miss.
- **Write–lookup race.** A write and a lookup share an edge. A design that bypassed new data would hit one cycle early.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int MIN_OFF = 12;

  function automatic logic size_legal(input logic [3:0] code);
    case (code)
      4'd1, 4'd3, 4'd5, 4'd7, 4'd10: return 1'b1;
      default:                       return 1'b0;
    endcase
  endfunction

  // page offset beyond the 12-bit minimum, in bits
  function automatic int size_shift(input logic [3:0] code);
    case (code)
      4'd3:    return 4;
      4'd5:    return 8;
      4'd7:    return 12;
      4'd10:   return 18;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N      = 16,
  parameter int EPN_W  = 52,
  parameter int RPN_W  = 30,
  parameter int LPID_W = 8,
  parameter int TID_W  = 14,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic                         wr_valid,
  input  logic [EPN_W-1:0]             wr_epn,
  input  logic                         wr_gs,
  input  logic [LPID_W-1:0]            wr_lpid,
  input  logic                         wr_ts,
  input  logic [TID_W-1:0]             wr_tid,
  input  logic [3:0]                   wr_size,
  input  logic                         wr_ind,
  input  logic [RPN_W-1:0]             wr_rpn,
  input  logic                         wr_perr_inject,
  output logic [N-1:0]                 e_valid,
  output logic [N-1:0][EPN_W-1:0]      e_epn,
  output logic [N-1:0]                 e_gs,
  output logic [N-1:0][LPID_W-1:0]     e_lpid,
  output logic [N-1:0]                 e_ts,
  output logic [N-1:0][TID_W-1:0]      e_tid,
  output logic [N-1:0][3:0]            e_size,
  output logic [N-1:0]                 e_ind,
  output logic [N-1:0][RPN_W-1:0]      e_rpn,
  output logic [N-1:0]                 e_par
);
  logic wr_par;
  assign wr_par = (^{wr_epn, wr_gs, wr_lpid, wr_ts, wr_tid, wr_size, wr_ind, wr_rpn})
                  ^ wr_perr_inject;

  // valid bits reset; payload is plain storage written by index
  always_ff @(posedge clk) begin
    if (rst) e_valid <= '0;
    else if (wr_en) e_valid[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_epn[wr_idx]  <= wr_epn;
      e_gs[wr_idx]   <= wr_gs;
      e_lpid[wr_idx] <= wr_lpid;
      e_ts[wr_idx]   <= wr_ts;
      e_tid[wr_idx]  <= wr_tid;
      e_size[wr_idx] <= wr_size;
      e_ind[wr_idx]  <= wr_ind;
      e_rpn[wr_idx]  <= wr_rpn;
      e_par[wr_idx]  <= wr_par;
    end
  end
endmodule

// File: rtl/tlb_cmp.sv
module tlb_cmp import tlb_pkg::*; #(
  parameter int N      = 16,
  parameter int EPN_W  = 52,
  parameter int RPN_W  = 30,
  parameter int LPID_W = 8,
  parameter int TID_W  = 14
) (
  input  logic [N-1:0]                 e_valid,
  input  logic [N-1:0][EPN_W-1:0]      e_epn,
  input  logic [N-1:0]                 e_gs,
  input  logic [N-1:0][LPID_W-1:0]     e_lpid,
  input  logic [N-1:0]                 e_ts,
  input  logic [N-1:0][TID_W-1:0]      e_tid,
  input  logic [N-1:0][3:0]            e_size,
  input  logic [N-1:0]                 e_ind,
  input  logic [N-1:0][RPN_W-1:0]      e_rpn,
  input  logic [N-1:0]                 e_par,
  input  logic [EPN_W-1:0]             lk_epn,
  input  logic                         lk_gs,
  input  logic [LPID_W-1:0]            lk_lpid,
  input  logic                         lk_ts,
  input  logic [TID_W-1:0]             lk_tid,
  output logic [N-1:0]                 hit_vec,
  output logic [N-1:0]                 perr_vec
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [EPN_W-1:0] emask;
    logic             tags_ok, epn_ok;
    assign emask   = {EPN_W{1'b1}} << size_shift(e_size[g]);
    assign tags_ok = (e_gs[g] == lk_gs) && (e_lpid[g] == lk_lpid) &&
                     (e_ts[g] == lk_ts) && (e_tid[g] == lk_tid);
    assign epn_ok  = ((e_epn[g] ^ lk_epn) & emask) == '0;
    assign hit_vec[g]  = e_valid[g] && size_legal(e_size[g]) && tags_ok && epn_ok;
    assign perr_vec[g] = ^{e_epn[g], e_gs[g], e_lpid[g], e_ts[g], e_tid[g],
                           e_size[g], e_ind[g], e_rpn[g], e_par[g]};
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any   = |vec;
  assign multi = |(vec & (vec - N'(1)));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate import tlb_pkg::*; #(
  parameter int N      = 16,
  parameter int EA_W   = 64,
  parameter int RA_W   = 42,
  parameter int LPID_W = 8,
  parameter int TID_W  = 14,
  localparam int IDX_W = $clog2(N),
  localparam int EPN_W = EA_W - MIN_OFF,
  localparam int RPN_W = RA_W - MIN_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [EPN_W-1:0]  wr_epn,
  input  logic              wr_gs,
  input  logic [LPID_W-1:0] wr_lpid,
  input  logic              wr_ts,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [3:0]        wr_size,
  input  logic              wr_ind,
  input  logic [RPN_W-1:0]  wr_rpn,
  input  logic              wr_perr_inject,
  input  logic              lk_valid,
  input  logic [EA_W-1:0]   lk_ea,
  input  logic              lk_gs,
  input  logic [LPID_W-1:0] lk_lpid,
  input  logic              lk_ts,
  input  logic [TID_W-1:0]  lk_tid,
  input  logic              lk_is_ifetch,
  input  logic              lk_is_cmo,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [IDX_W-1:0]  rs_idx,
  output logic              rs_ind,
  output logic [RA_W-1:0]   rs_ra,
  output logic              rs_imiss,
  output logic              rs_dmiss,
  output logic              rs_multi,
  output logic              rs_perr
);
  logic [N-1:0]              e_valid, e_gs, e_ts, e_ind, e_par;
  logic [N-1:0][EPN_W-1:0]   e_epn;
  logic [N-1:0][LPID_W-1:0]  e_lpid;
  logic [N-1:0][TID_W-1:0]   e_tid;
  logic [N-1:0][3:0]         e_size;
  logic [N-1:0][RPN_W-1:0]   e_rpn;
  logic [N-1:0]              hit_vec, perr_vec;
  logic [IDX_W-1:0]          sel;
  logic                      any_hit, multi_hit;
  logic [RPN_W-1:0]          rmask;
  logic [RA_W-1:0]           ra_next;
  logic                      sel_ind;

  tlb_store #(.N(N), .EPN_W(EPN_W), .RPN_W(RPN_W), .LPID_W(LPID_W), .TID_W(TID_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_epn(wr_epn), .wr_gs(wr_gs), .wr_lpid(wr_lpid), .wr_ts(wr_ts), .wr_tid(wr_tid),
    .wr_size(wr_size), .wr_ind(wr_ind), .wr_rpn(wr_rpn), .wr_perr_inject(wr_perr_inject),
    .e_valid(e_valid), .e_epn(e_epn), .e_gs(e_gs), .e_lpid(e_lpid), .e_ts(e_ts),
    .e_tid(e_tid), .e_size(e_size), .e_ind(e_ind), .e_rpn(e_rpn), .e_par(e_par)
  );

  tlb_cmp #(.N(N), .EPN_W(EPN_W), .RPN_W(RPN_W), .LPID_W(LPID_W), .TID_W(TID_W)) u_cmp (
    .e_valid(e_valid), .e_epn(e_epn), .e_gs(e_gs), .e_lpid(e_lpid), .e_ts(e_ts),
    .e_tid(e_tid), .e_size(e_size), .e_ind(e_ind), .e_rpn(e_rpn), .e_par(e_par),
    .lk_epn(lk_ea[EA_W-1:MIN_OFF]), .lk_gs(lk_gs), .lk_lpid(lk_lpid), .lk_ts(lk_ts),
    .lk_tid(lk_tid), .hit_vec(hit_vec), .perr_vec(perr_vec)
  );

  tlb_pick #(.N(N)) u_pick (.vec(hit_vec), .idx(sel), .any(any_hit), .multi(multi_hit));

  // real address: stored page number above the offset, effective offset below
  assign rmask   = {RPN_W{1'b1}} << size_shift(e_size[sel]);
  assign ra_next = {(e_rpn[sel] & rmask) | (lk_ea[RA_W-1:MIN_OFF] & ~rmask),
                    lk_ea[MIN_OFF-1:0]};
  assign sel_ind = e_ind[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0; rs_hit <= 1'b0; rs_idx <= '0; rs_ind <= 1'b0; rs_ra <= '0;
      rs_imiss <= 1'b0; rs_dmiss <= 1'b0; rs_multi <= 1'b0; rs_perr <= 1'b0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_valid & any_hit;
      rs_idx   <= lk_valid ? sel : '0;
      rs_ind   <= lk_valid & any_hit & sel_ind;
      rs_ra    <= (lk_valid & any_hit & ~sel_ind) ? ra_next : '0;
      rs_imiss <= lk_valid & ~any_hit & lk_is_ifetch;
      rs_dmiss <= lk_valid & ~any_hit & ~lk_is_ifetch & ~lk_is_cmo;
      rs_multi <= lk_valid & multi_hit;
      rs_perr  <= lk_valid & |(hit_vec & perr_vec);
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int N    = 16,
  parameter int EA_W = 64,
  parameter int RA_W = 42,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [EA_W-1:0]  lk_ea,
  input logic             lk_is_ifetch,
  input logic             lk_is_cmo,
  input logic             rs_valid,
  input logic             rs_hit,
  input logic             rs_ind,
  input logic [RA_W-1:0]  rs_ra,
  input logic             rs_imiss,
  input logic             rs_dmiss,
  input logic             rs_multi,
  input logic             rs_perr
);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rs_valid && !rs_hit && !rs_imiss && !rs_dmiss && !rs_perr));
  a_r6_imiss_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_is_ifetch) |=> !rs_imiss);
  a_r7_cmo_silent: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_is_cmo) |=> !rs_dmiss);
  a_r7_fetch_no_dmiss: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_is_ifetch) |=> !rs_dmiss);
  a_r8_multi_implies_hit: assert property (@(posedge clk) disable iff (rst)
    rs_multi |-> rs_hit);
  a_r3_outcome_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rs_hit, rs_imiss, rs_dmiss}));
  a_r4_offset_passthrough: assert property (@(posedge clk) disable iff (rst)
    (lk_valid) |=> ((rs_hit && !rs_ind) -> (rs_ra[11:0] == $past(lk_ea[11:0]))));
  a_r5_ind_no_address: assert property (@(posedge clk) disable iff (rst)
    rs_ind |-> (rs_hit && rs_ra == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.N(N), .EA_W(EA_W), .RA_W(RA_W)) u_chk (.*);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic wr_en = 0, wr_valid = 0, wr_gs = 0, wr_ts = 0, wr_ind = 0, wr_perr_inject = 0;
  logic [3:0] wr_idx = 0, wr_size = 0;
  logic [51:0] wr_epn = 0;
  logic [7:0] wr_lpid = 0;
  logic [13:0] wr_tid = 0;
  logic [29:0] wr_rpn = 0;
  logic lk_valid = 0, lk_gs = 0, lk_ts = 0, lk_is_ifetch = 0, lk_is_cmo = 0;
  logic [63:0] lk_ea = 0;
  logic [7:0] lk_lpid = 0;
  logic [13:0] lk_tid = 0;
  logic rs_valid, rs_hit, rs_ind, rs_imiss, rs_dmiss, rs_multi, rs_perr;
  logic [3:0] rs_idx;
  logic [41:0] rs_ra;

  tlb_xlate i_tlb_xlate (.*);

  int vectors = 0, errors = 0;

  // shadow of written entries
  logic sv[16], sgs[16], sts[16], sind[16], sbad[16];
  logic [51:0] sepn[16];
  logic [7:0] slpid[16];
  logic [13:0] stid[16];
  logic [3:0] ssz[16];
  logic [29:0] srpn[16];

  // expected results
  logic x_valid, x_hit, x_ind, x_im, x_dm, x_mul, x_per;
  logic [3:0] x_idx;
  logic [41:0] x_ra;

  function automatic int boff(input logic [3:0] c);
    case (c)
      4'd1: return 12; 4'd3: return 16; 4'd5: return 20; 4'd7: return 24; 4'd10: return 30;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model(input logic lv, input logic [63:0] ea, input logic gs,
                       input logic [7:0] lp, input logic ts, input logic [13:0] tid,
                       input logic ifc, input logic cmo);
    int cnt;
    logic [63:0] pm;
    cnt = 0; x_valid = lv; x_hit = 0; x_idx = 0; x_ind = 0; x_ra = 0; x_per = 0;
    for (int i = 0; i < 16; i++) begin
      int o;
      o = boff(ssz[i]);
      if (sv[i] && o > 0 && ((ea >> o) == ({sepn[i], 12'h000} >> o)) &&
          sgs[i] == gs && slpid[i] == lp && sts[i] == ts && stid[i] == tid) begin
        if (cnt == 0) begin
          x_idx = 4'(i); x_ind = sind[i];
          pm = (64'd1 << o) - 64'd1;
          x_ra = ({srpn[i], 12'h000} & ~pm[41:0]) | (ea[41:0] & pm[41:0]);
        end
        if (sbad[i]) x_per = 1;
        cnt++;
      end
    end
    x_hit = lv && cnt > 0;
    x_mul = lv && cnt > 1;
    x_per = lv && x_per;
    if (!x_hit || x_ind) x_ra = 0;
    if (!x_hit) x_ind = 0;
    x_im = lv && cnt == 0 && ifc;
    x_dm = lv && cnt == 0 && !ifc && !cmo;
  endtask

  task automatic check_out();
    vectors++;
    chk("R10 rs_valid", 64'(rs_valid), 64'(x_valid));
    chk("R3 rs_hit", 64'(rs_hit), 64'(x_hit));
    if (x_hit) chk("R8 rs_idx", 64'(rs_idx), 64'(x_idx));
    chk("R5 rs_ind", 64'(rs_ind), 64'(x_ind));
    chk("R4 rs_ra", 64'(rs_ra), 64'(x_ra));
    chk("R6 rs_imiss", 64'(rs_imiss), 64'(x_im));
    chk("R7 rs_dmiss", 64'(rs_dmiss), 64'(x_dm));
    chk("R8 rs_multi", 64'(rs_multi), 64'(x_mul));
    chk("R9 rs_perr", 64'(rs_perr), 64'(x_per));
  endtask

  task automatic drive_wr(input int i, input logic v, input logic [51:0] epn, input logic gs,
                          input logic [7:0] lp, input logic ts, input logic [13:0] tid,
                          input logic [3:0] sz, input logic ind, input logic [29:0] rpn,
                          input logic inj);
    wr_en = 1; wr_idx = 4'(i); wr_valid = v; wr_epn = epn; wr_gs = gs; wr_lpid = lp;
    wr_ts = ts; wr_tid = tid; wr_size = sz; wr_ind = ind; wr_rpn = rpn; wr_perr_inject = inj;
  endtask

  task automatic shadow(input int i);
    sv[i] = wr_valid; sepn[i] = wr_epn; sgs[i] = wr_gs; slpid[i] = wr_lpid; sts[i] = wr_ts;
    stid[i] = wr_tid; ssz[i] = wr_size; sind[i] = wr_ind; srpn[i] = wr_rpn;
    sbad[i] = wr_perr_inject;
  endtask

  task automatic write(input int i, input logic v, input logic [51:0] epn, input logic gs,
                       input logic [7:0] lp, input logic ts, input logic [13:0] tid,
                       input logic [3:0] sz, input logic ind, input logic [29:0] rpn,
                       input logic inj);
    @(negedge clk);
    drive_wr(i, v, epn, gs, lp, ts, tid, sz, ind, rpn, inj);
    @(negedge clk);
    wr_en = 0;
    shadow(i);
  endtask

  task automatic look(input logic lv, input logic [63:0] ea, input logic gs,
                      input logic [7:0] lp, input logic ts, input logic [13:0] tid,
                      input logic ifc, input logic cmo);
    @(negedge clk);
    lk_valid = lv; lk_ea = ea; lk_gs = gs; lk_lpid = lp; lk_ts = ts; lk_tid = tid;
    lk_is_ifetch = ifc; lk_is_cmo = cmo;
    model(lv, ea, gs, lp, ts, tid, ifc, cmo);
    @(negedge clk);
    lk_valid = 0;
    check_out();
  endtask

  function automatic logic [63:0] ea_in(input int i);
    int o;
    logic [63:0] pm;
    o = boff(ssz[i]);
    if (o < 0) o = 12;
    pm = (64'd1 << o) - 64'd1;
    return ({sepn[i], 12'h000} & ~pm) | ({$urandom, $urandom} & pm);
  endfunction

  // probe entry i: hit, page-number bit flip, offset bit flip, each tag flip
  task automatic probe(input int i);
    logic [63:0] ea;
    int o;
    o = boff(ssz[i]);
    if (o < 0) o = 12;
    ea = ea_in(i);
    look(1, ea, sgs[i], slpid[i], sts[i], stid[i], 1'($urandom), 1'($urandom));
    look(1, ea ^ (64'd1 << o), sgs[i], slpid[i], sts[i], stid[i], 1'($urandom), 1'($urandom));
    look(1, ea ^ (64'd1 << (o - 1)), sgs[i], slpid[i], sts[i], stid[i], 0, 0);
    look(1, ea, ~sgs[i], slpid[i], sts[i], stid[i], 0, 0);
    look(1, ea, sgs[i], slpid[i] ^ 8'h80, sts[i], stid[i], 1, 0);
    look(1, ea, sgs[i], slpid[i], ~sts[i], stid[i], 0, 1);
    look(1, ea, sgs[i], slpid[i], sts[i], stid[i] ^ 14'h2000, 1, 1);
  endtask

  localparam logic [3:0] CODES [16] = '{4'd1, 4'd3, 4'd5, 4'd7, 4'd10, 4'd1, 4'd3, 4'd5,
                                        4'd7, 4'd10, 4'd1, 4'd3, 4'd5, 4'd10, 4'd2, 4'd0};

  initial begin
    for (int i = 0; i < 16; i++) begin
      sv[i] = 0; sepn[i] = 0; sgs[i] = 0; slpid[i] = 0; sts[i] = 0; stid[i] = 0;
      ssz[i] = 0; sind[i] = 0; srpn[i] = 0; sbad[i] = 0;
    end
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state of results and of entries
    model(0, 0, 0, 0, 0, 0, 0, 0);
    check_out();
    for (int k = 0; k < 4; k++)
      look(1, {$urandom, $urandom}, 0, 0, 0, 0, 1'(k), 1'(k >> 1));

    // fill: every legal size code plus two illegal ones (R2), two indirect entries (R5)
    for (int i = 0; i < 16; i++) begin
      logic [51:0] e;
      e = {$urandom, $urandom};
      e[51:48] = 4'(i);
      write(i, 1, e, 1'($urandom), 8'($urandom), 1'($urandom), 14'($urandom),
            CODES[i], (i == 4 || i == 9), 30'($urandom), 0);
    end
    // R2 R3 R4 R5 R6 R7: per-entry probes
    for (int i = 0; i < 16; i++) probe(i);

    // R6 R7: all access-kind combinations on a miss and on a hit
    for (int k = 0; k < 4; k++) begin
      look(1, {4'hF, 60'h0}, 0, 0, 0, 0, 1'(k), 1'(k >> 1));
      look(1, ea_in(2), sgs[2], slpid[2], sts[2], stid[2], 1'(k), 1'(k >> 1));
    end

    // R8: duplicate of entry 3 at index 12 with a different real page
    write(12, 1, sepn[3], sgs[3], slpid[3], sts[3], stid[3], ssz[3], 0, ~srpn[3], 0);
    look(1, ea_in(3), sgs[3], slpid[3], sts[3], stid[3], 0, 0);
    // R8: larger page at index 1 covering a small page placed at index 13
    write(13, 1, sepn[1] ^ 52'h1, sgs[1], slpid[1], sts[1], stid[1], 4'd1, 0, 30'h155, 0);
    look(1, {sepn[1] ^ 52'h1, 12'h abc}, sgs[1], slpid[1], sts[1], stid[1], 1, 0);

    // R9: injected parity error on index 6, clean neighbour still fine
    write(6, 1, sepn[6], sgs[6], slpid[6], sts[6], stid[6], ssz[6], 0, srpn[6], 1);
    look(1, ea_in(6), sgs[6], slpid[6], sts[6], stid[6], 0, 0);
    look(1, ea_in(7), sgs[7], slpid[7], sts[7], stid[7], 0, 0);

    // R10: write and lookup at the same edge see old contents, next cycle sees new
    @(negedge clk);
    drive_wr(0, 1, {4'hE, 48'h123456789}, 1, 8'h5A, 0, 14'h0042, 4'd5, 0, 30'h2ABCD, 0);
    lk_valid = 1; lk_ea = {4'hE, 48'h123456789, 12'h777}; lk_gs = 1; lk_lpid = 8'h5A;
    lk_ts = 0; lk_tid = 14'h0042; lk_is_ifetch = 0; lk_is_cmo = 0;
    model(1, lk_ea, 1, 8'h5A, 0, 14'h0042, 0, 0);
    @(negedge clk);
    wr_en = 0; lk_valid = 0;
    shadow(0);
    check_out();
    look(1, {4'hE, 48'h123456789, 12'h777}, 1, 8'h5A, 0, 14'h0042, 0, 0);

    // invalidate entry 2, then lookups with lk_valid low (R11)
    write(2, 0, sepn[2], sgs[2], slpid[2], sts[2], stid[2], ssz[2], 0, srpn[2], 0);
    look(1, ea_in(2), sgs[2], slpid[2], sts[2], stid[2], 0, 0);
    look(0, ea_in(5), sgs[5], slpid[5], sts[5], stid[5], 1, 0);
    look(0, 64'h0, 0, 0, 0, 0, 0, 0);

    // sweep: random entry, random perturbation
    for (int n = 0; n < 400; n++) begin
      int i;
      logic [63:0] ea;
      i = int'($urandom_range(15));
      ea = ea_in(i);
      if ($urandom_range(3) == 0) ea = ea ^ (64'd1 << $urandom_range(63));
      look(1, ea, sgs[i], slpid[i], sts[i], stid[i], 1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule